// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Matcher

The matcher watches a processor bus and raises a break request when a bus access meets a programmed condition. There are two channels. Each compares the access address under a selectable low-bit mask, compares an 8-bit address-space ID (or ignores it), and qualifies the access by operand size, direction and kind (instruction fetch or data). The second channel can also demand that the bus data equal a programmed value under a data mask.

A shared control register picks how the channels combine. In independent mode either channel breaks on its own. In sequential mode a hit on the first channel only arms the unit, and a later hit on the second channel breaks. Each channel has a sticky hit flag. For instruction fetches, each channel can defer its break until the fetched instruction retires. All state is written and read through a small register port. Each bus access is marked by a one-cycle valid strobe.

Top module: `bus_brk_unit`

Register offsets on `reg_addr`: 0 first-channel address, 1 first-channel mask select, 2 first-channel ID, 3 first-channel qualifier, 4 second-channel address, 5 second-channel mask select, 6 second-channel ID, 7 second-channel qualifier, 8 compare data, 9 data mask, 10 control.

## Requirements
- R1: After reset every register reads 0, `brk` is low, and a channel whose qualifier is 0 never hits.
- R2: Mask select is built from bits {3,1,0} of the mask register. Code 0x0 compares all 32 address bits, 0x1 ignores the low 10, 0x2 the low 12, 0x8 the low 16, 0x9 the low 20, and 0x3 ignores the whole address.
- R3: A channel hits only if the access ID equals its 8-bit ID register, unless bit 2 (0x04) of its mask register is set, in which case any ID hits.
- R4: Qualifier size field {bit6,bit1,bit0}: 0 any size, 0x01 8-bit, 0x02 16-bit, 0x03 32-bit, 0x40 64-bit. `bus_size` codes 0/1/2/3 mean 8/16/32/64 bits.
- R5: Qualifier bit 0x04 allows reads and 0x08 allows writes. Both set means either direction. Neither set means the channel never hits.
- R6: Qualifier bit 0x10 allows instruction fetches and 0x20 allows data accesses, with the same rule as R5.
- R7: When control bit 0x0080 is set, the second channel also needs `bus_data` to equal the compare data in every bit where the data mask is 0. When it is clear, data is not compared.
- R8: With control bit 0x0008 clear, a hit on either channel makes `brk` high for exactly the cycle after the access.
- R9: With control bit 0x0008 set, a first-channel hit arms the unit and a second-channel hit on a later access breaks. Breaking, reset and any control write disarm the unit. A second-channel hit while unarmed does not break.
- R10: Control bits 0x8000 and 0x4000 record hits on the first and second channel. A control write of 0 to a flag clears it, and a write of 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves the flag set.
- R11: When control bit 0x0400 (first channel) or 0x0040 (second channel) is set, a break caused by an instruction fetch on that channel is deferred. `brk` then pulses the cycle after the next `retire` strobe that arrives after the fetch. A retire with nothing deferred does nothing.
- R12: Written register values read back on `reg_rdata` at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | One-cycle strobe marking a bus access |
| bus_addr | input | 32 | Access address |
| bus_asid | input | 8 | Access address-space ID |
| bus_data | input | 32 | Access data |
| bus_size | input | 2 | Operand size code |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_ifetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| retire | input | 1 | Strobe marking that the fetched instruction retired |
| brk | output | 1 | One-cycle break request |

## Verification
A software write that clears the sticky flags can land in the same cycle as a bus access that hits. The bench drives a control write of 0 together with a matching access on the first channel. It expects the break pulse the next cycle and a flag that reads back still set, because the new hit must win over the clear. A second control write with no access then reads back 0, which confirms that the clear works on its own.

// File: rtl/bus_brk_unit.sv
module bus_brk_unit #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [3:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           bus_valid,
  input  logic [AW-1:0]  bus_addr,
  input  logic [IDW-1:0] bus_asid,
  input  logic [DW-1:0]  bus_data,
  input  logic [1:0]     bus_size,
  input  logic           bus_write,
  input  logic           bus_ifetch,
  input  logic           retire,
  output logic           brk
);
  localparam logic [3:0] OFS_CTRL  = 4'd10;
  localparam logic [3:0] OFS_DATA  = 4'd8;
  localparam logic [3:0] OFS_DMASK = 4'd9;

  logic [AW-1:0]  ch_addr [2];
  logic [3:0]     ch_mask [2];
  logic [IDW-1:0] ch_asid [2];
  logic [6:0]     ch_qual [2];
  logic [DW-1:0]  cmp_data, cmp_dmask;
  logic c_seq, c_bdata, c_aafter, c_bafter, flag_a, flag_b;
  logic armed, pending;
  logic [1:0] hit;

  wire ctl_wr = reg_we && (reg_addr == OFS_CTRL);

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic [AW-1:0] ign;
    logic size_ok, dir_ok, kind_ok, asid_ok, addr_ok, data_ok;
    always_comb begin
      int n;
      case ({ch_mask[i][3], ch_mask[i][1:0]})
        3'b001:  n = 10;
        3'b010:  n = 12;
        3'b100:  n = 16;
        3'b101:  n = 20;
        default: n = 0;
      endcase
      ign = ({ch_mask[i][3], ch_mask[i][1:0]} == 3'b011) ? '1 : ~({AW{1'b1}} << n);
      case ({ch_qual[i][6], ch_qual[i][1:0]})
        3'b000:  size_ok = 1'b1;
        3'b001:  size_ok = (bus_size == 2'd0);
        3'b010:  size_ok = (bus_size == 2'd1);
        3'b011:  size_ok = (bus_size == 2'd2);
        3'b100:  size_ok = (bus_size == 2'd3);
        default: size_ok = 1'b0;
      endcase
    end
    assign dir_ok  = bus_write  ? ch_qual[i][3] : ch_qual[i][2];
    assign kind_ok = bus_ifetch ? ch_qual[i][4] : ch_qual[i][5];
    assign asid_ok = ch_mask[i][2] || (bus_asid == ch_asid[i]);
    assign addr_ok = ((bus_addr ^ ch_addr[i]) & ~ign) == '0;
    if (i == 1) begin : g_data
      assign data_ok = !c_bdata || (((bus_data ^ cmp_data) & ~cmp_dmask) == '0);
    end else begin : g_nodata
      assign data_ok = 1'b1;
    end
    assign hit[i] = bus_valid && size_ok && dir_ok && kind_ok && asid_ok && addr_ok && data_ok;
  end

  wire after_a = c_aafter && bus_ifetch;
  wire after_b = c_bafter && bus_ifetch;
  wire trig_a  = hit[0] && !c_seq;
  wire trig_b  = hit[1] && (!c_seq || armed);
  wire now_brk = (trig_a && !after_a) || (trig_b && !after_b);
  wire defer   = !now_brk && ((trig_a && after_a) || (trig_b && after_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        ch_addr[i] <= '0;
        ch_mask[i] <= '0;
        ch_asid[i] <= '0;
        ch_qual[i] <= '0;
      end
      cmp_data  <= '0;
      cmp_dmask <= '0;
      c_seq     <= 1'b0;
      c_bdata   <= 1'b0;
      c_aafter  <= 1'b0;
      c_bafter  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        4'd0:  ch_addr[0] <= reg_wdata[AW-1:0];
        4'd1:  ch_mask[0] <= reg_wdata[3:0];
        4'd2:  ch_asid[0] <= reg_wdata[IDW-1:0];
        4'd3:  ch_qual[0] <= reg_wdata[6:0];
        4'd4:  ch_addr[1] <= reg_wdata[AW-1:0];
        4'd5:  ch_mask[1] <= reg_wdata[3:0];
        4'd6:  ch_asid[1] <= reg_wdata[IDW-1:0];
        4'd7:  ch_qual[1] <= reg_wdata[6:0];
        OFS_DATA:  cmp_data  <= reg_wdata[DW-1:0];
        OFS_DMASK: cmp_dmask <= reg_wdata[DW-1:0];
        OFS_CTRL: begin
          c_seq    <= reg_wdata[3];
          c_bdata  <= reg_wdata[7];
          c_bafter <= reg_wdata[6];
          c_aafter <= reg_wdata[10];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a  <= 1'b0;
      flag_b  <= 1'b0;
      armed   <= 1'b0;
      pending <= 1'b0;
      brk     <= 1'b0;
    end else begin
      flag_a  <= (ctl_wr ? (flag_a && reg_wdata[15]) : flag_a) || hit[0];
      flag_b  <= (ctl_wr ? (flag_b && reg_wdata[14]) : flag_b) || hit[1];
      if (ctl_wr || (c_seq && trig_b)) armed <= 1'b0;
      else if (c_seq && hit[0])        armed <= 1'b1;
      pending <= defer || (pending && !retire);
      brk     <= now_brk || (pending && retire);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      4'd0:  reg_rdata[AW-1:0]  = ch_addr[0];
      4'd1:  reg_rdata[3:0]     = ch_mask[0];
      4'd2:  reg_rdata[IDW-1:0] = ch_asid[0];
      4'd3:  reg_rdata[6:0]     = ch_qual[0];
      4'd4:  reg_rdata[AW-1:0]  = ch_addr[1];
      4'd5:  reg_rdata[3:0]     = ch_mask[1];
      4'd6:  reg_rdata[IDW-1:0] = ch_asid[1];
      4'd7:  reg_rdata[6:0]     = ch_qual[1];
      OFS_DATA:  reg_rdata[DW-1:0] = cmp_data;
      OFS_DMASK: reg_rdata[DW-1:0] = cmp_dmask;
      OFS_CTRL: begin
        reg_rdata[15] = flag_a;
        reg_rdata[14] = flag_b;
        reg_rdata[10] = c_aafter;
        reg_rdata[7]  = c_bdata;
        reg_rdata[6]  = c_bafter;
        reg_rdata[3]  = c_seq;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_brk_unit_chk.sv
module bus_brk_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic       bus_valid,
  input logic       retire,
  input logic       brk,
  input logic       flag_a,
  input logic       flag_b,
  input logic       armed,
  input logic       c_seq
);
  AST_QUIET_WITHOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid && !retire) |=> !brk); // R8

  AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_a && !(reg_we && reg_addr == 4'd10)) |=> flag_a); // R10

  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_b && !(reg_we && reg_addr == 4'd10)) |=> flag_b); // R10

  AST_FLAG_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !$rose(flag_a) && !$rose(flag_b)); // R10

  AST_ARM_ONLY_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> c_seq); // R9

  AST_CTRL_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd10) |=> !armed); // R9
endmodule

bind bus_brk_unit bus_brk_unit_chk chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .bus_valid(bus_valid), .retire(retire), .brk(brk),
  .flag_a(flag_a), .flag_b(flag_b), .armed(armed), .c_seq(c_seq)
);

// File: tb/bus_brk_unit_test.sv
module bus_brk_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, bus_valid = 0, bus_write = 0, bus_ifetch = 0, retire = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, bus_addr = 0, bus_data = 0, reg_rdata;
  logic [7:0] bus_asid = 0;
  logic [1:0] bus_size = 0;
  logic brk;
  int vectors = 0, errors = 0;
  bit done = 0;

  typedef struct { bit exp; string tag; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  bus_brk_unit uut (.*);

  task automatic push(bit e, string t);
    item_t it;
    it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d; bus_valid = 0; retire = 0;
    push(0, "write");
  endtask

  task automatic acc(logic [31:0] a, logic [7:0] id, logic [31:0] d, logic [1:0] sz,
                     bit w, bit f, bit e, string t);
    @(negedge clk);
    reg_we = 0; retire = 0; bus_valid = 1;
    bus_addr = a; bus_asid = id; bus_data = d; bus_size = sz; bus_write = w; bus_ifetch = f;
    push(e, t);
  endtask

  task automatic wr_acc(logic [31:0] d, logic [31:0] a, logic [7:0] id, bit e, string t);
    @(negedge clk);
    reg_we = 1; reg_addr = 4'd10; reg_wdata = d; retire = 0; bus_valid = 1;
    bus_addr = a; bus_asid = id; bus_data = 0; bus_size = 2; bus_write = 0; bus_ifetch = 0;
    push(e, t);
  endtask

  task automatic idle(bit r, bit e, string t);
    @(negedge clk);
    reg_we = 0; bus_valid = 0; retire = r;
    push(e, t);
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] e, string t);
    @(negedge clk);
    reg_we = 0; bus_valid = 0; retire = 0; reg_addr = a;
    push(0, "read");
    #1;
    vectors++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s: rdata act %08h exp %08h", t, reg_rdata, e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        vectors++;
        if (brk !== it.exp) begin
          errors++;
          $display("FAIL %s: brk act %0b exp %0b", it.tag, brk, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act timeout exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  localparam logic [31:0] AADR = 32'h1234_5678, BADR = 32'h0000_1000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'd10, 0, "R1 ctrl reset");
    rd(4'd3, 0, "R1 qual reset");
    acc(AADR, 8'h11, 0, 2, 0, 0, 0, "R1 zero qual no hit");
    wr(4'd0, AADR); rd(4'd0, AADR, "R12 addr readback");
    wr(4'd2, 32'h11); rd(4'd2, 32'h11, "R12 id readback");
    wr(4'd3, 32'h27); rd(4'd3, 32'h27, "R12 qual readback");
    acc(AADR, 8'h11, 0, 2, 0, 0, 1, "R8 channel A hit");
    rd(4'd10, 32'h8000, "R10 flag A set");
    wr(4'd10, 32'h8000); rd(4'd10, 32'h8000, "R10 write 1 keeps");
    wr(4'd10, 32'h4000); rd(4'd10, 32'h0, "R10 write 0 clears");
    acc(AADR + 1, 8'h11, 0, 2, 0, 0, 0, "R2 exact miss");
    acc(AADR, 8'h12, 0, 2, 0, 0, 0, "R3 id miss");
    acc(AADR, 8'h11, 0, 1, 0, 0, 0, "R4 size miss");
    acc(AADR, 8'h11, 0, 2, 1, 0, 0, "R5 write miss");
    acc(AADR, 8'h11, 0, 2, 0, 1, 0, "R6 fetch miss");
    rd(4'd10, 32'h0, "R10 no flag on misses");
    wr(4'd1, 32'h1);
    acc(32'h1234_57FF, 8'h11, 0, 2, 0, 0, 1, "R2 low10 hit");
    acc(32'h1234_5800, 8'h11, 0, 2, 0, 0, 0, "R2 low10 miss");
    wr(4'd1, 32'h2);
    acc(32'h1234_5FFF, 8'h11, 0, 2, 0, 0, 1, "R2 low12 hit");
    acc(32'h1234_6000, 8'h11, 0, 2, 0, 0, 0, "R2 low12 miss");
    wr(4'd1, 32'h9);
    acc(32'h123A_BCDE, 8'h11, 0, 2, 0, 0, 1, "R2 low20 hit");
    acc(32'h124A_BCDE, 8'h11, 0, 2, 0, 0, 0, "R2 low20 miss");
    wr(4'd1, 32'h3);
    acc(32'hDEAD_BEEF, 8'h11, 0, 2, 0, 0, 1, "R2 whole address ignored");
    wr(4'd1, 32'hC);
    acc(32'h1234_FFFF, 8'h55, 0, 2, 0, 0, 1, "R3 id ignored low16 hit");
    acc(32'h1235_0000, 8'h55, 0, 2, 0, 0, 0, "R2 low16 miss");
    wr(4'd1, 32'h0);
    wr(4'd3, 32'h24);
    acc(AADR, 8'h11, 0, 0, 0, 0, 1, "R4 any size");
    wr(4'd3, 32'h6C);
    acc(AADR, 8'h11, 0, 3, 1, 0, 1, "R4 64-bit write hit");
    acc(AADR, 8'h11, 0, 3, 0, 0, 1, "R5 both directions read hit");
    acc(AADR, 8'h11, 0, 2, 1, 0, 0, "R4 32-bit vs 64 miss");
    wr(4'd3, 32'h34);
    acc(AADR, 8'h11, 0, 2, 0, 1, 1, "R6 fetch hit");
    acc(AADR, 8'h11, 0, 2, 0, 0, 1, "R6 data hit");
    wr(4'd3, 32'h20);
    acc(AADR, 8'h11, 0, 2, 0, 0, 0, "R5 no direction never");
    wr(4'd3, 32'h27);
    wr(4'd10, 32'h0);
    wr_acc(32'h0, AADR, 8'h11, 1, "R10 clear and hit same cycle");
    rd(4'd10, 32'h8000, "R10 hit wins over clear");
    wr(4'd10, 32'h0); rd(4'd10, 32'h0, "R10 clear alone");
    // channel B data compare
    wr(4'd3, 32'h0);
    wr(4'd4, BADR); wr(4'd6, 32'h22); wr(4'd7, 32'h27);
    wr(4'd8, 32'hCAFE_0000); wr(4'd9, 32'h0000_FFFF);
    rd(4'd9, 32'h0000_FFFF, "R12 dmask readback");
    wr(4'd10, 32'h0080);
    acc(BADR, 8'h22, 32'hCAFE_1234, 2, 0, 0, 1, "R7 data hit");
    acc(BADR, 8'h22, 32'hCAFF_0000, 2, 0, 0, 0, "R7 data miss");
    rd(4'd10, 32'h4080, "R10 flag B set");
    wr(4'd10, 32'h0);
    acc(BADR, 8'h22, 32'hCAFF_0000, 2, 0, 0, 1, "R7 data compare off");
    // sequential
    wr(4'd3, 32'h27);
    wr(4'd10, 32'h0008);
    acc(BADR, 8'h22, 0, 2, 0, 0, 0, "R9 B unarmed");
    acc(AADR, 8'h11, 0, 2, 0, 0, 0, "R9 A arms only");
    acc(BADR, 8'h22, 0, 2, 0, 0, 1, "R9 B after A breaks");
    acc(BADR, 8'h22, 0, 2, 0, 0, 0, "R9 disarmed by break");
    acc(AADR, 8'h11, 0, 2, 0, 0, 0, "R9 A arms again");
    wr(4'd10, 32'h0008);
    acc(BADR, 8'h22, 0, 2, 0, 0, 0, "R9 disarmed by ctrl write");
    wr(4'd1, 32'h7);
    acc(BADR, 8'h22, 0, 2, 0, 0, 0, "R9 same access not later");
    acc(BADR, 8'h22, 0, 2, 0, 0, 1, "R9 next access breaks");
    // after-execution
    wr(4'd1, 32'h0);
    wr(4'd10, 32'h0400);
    wr(4'd3, 32'h34);
    acc(AADR, 8'h11, 0, 2, 0, 1, 0, "R11 fetch deferred");
    idle(0, 0, "R11 wait");
    idle(1, 1, "R11 retire releases");
    idle(0, 0, "R11 single pulse");
    idle(1, 0, "R11 retire alone");
    acc(AADR, 8'h11, 0, 2, 0, 0, 1, "R11 data not deferred");
    idle(0, 0, "drain");
    idle(0, 0, "drain");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule